// File: doc/BRIEF.md
# Configuration-Space Watchdog Timer with Pulse or Level Reset

This block is a watchdog timer that sits in one logical device of a byte-wide configuration space. Software reaches it through a per-device write strobe, an 8-bit register index, write data and a combinational read-data return. A prescaler turns the core clock into millisecond ticks. A second divider turns those into second or minute ticks. An 8-bit down-counter consumes the second or minute ticks. Every write of the count register reloads the counter, and that reload is the keepalive.

The counter runs only while both the device-activate bit and the watchdog-enable bit are set. When it steps from one to zero, a sticky expiry flag is set. An internal reset request is also raised. The request drives the active-low reset pin when the output gate is open. It is either held as a level, or released after one of four coded pulse widths counted in milliseconds. Pin multiplexing and the reset's effect on the system are outside the block.

Top module: `wdog_ldev`

## Requirements
- R1: After reset every register reads 0x00 and `wdt_rst_n` is high.
- R2: Writing index 0xF6 loads the 8-bit count and restarts the prescalers. With seconds selected and the timer running, a count of N expires exactly N*CLK_PER_MS*MS_PER_SEC clocks after the write edge. Index 0xF6 reads back the live count.
- R3: Index 0xF5 bit 3 = 1 selects minutes. A count of N then expires N*CLK_PER_MS*MS_PER_SEC*SEC_PER_MIN clocks after the write.
- R4: The count advances only while index 0x30 bit 0 (device activate) and index 0xF5 bit 5 (enable, written) are both 1. Otherwise it holds its value.
- R5: On expiry, index 0xF5 read bit 5 (expiry flag) becomes 1 and the reset request is raised.
- R6: With index 0xF5 bit 4 = 0 (level), the request stays raised until a write clears enable bit 5 or a write of 0xF6 reloads the count.
- R7: With index 0xF5 bit 4 = 1 (pulse), the request lasts PW_0, PW_1, PW_2 or PW_3 milliseconds for bits 1:0 = 0, 1, 2, 3. The defaults are 1, 25, 125 and 5000 ms.
- R8: `wdt_rst_n` is low only while index 0xF0 bit 7 (output gate) is 1 and the request is raised. A gated-off expiry still sets the flag.
- R9: The expiry flag survives clearing the enable bit. It is cleared by a write of 0xF5 with bit 5 = 1.
- R10: A count of zero leaves the timer idle: no flag and no request, even while enabled.
- R11: A reload write that lands in the same cycle as the final decrement wins. No expiry occurs, and the new count starts afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_wr | input | 1 | Write strobe for this logical device |
| dev_addr | input | 8 | Register index for write and read |
| dev_wdata | input | 8 | Write data |
| dev_rdata | output | 8 | Read data for `dev_addr` (combinational) |
| wdt_rst_n | output | 1 | Active-low watchdog reset output |

## Verification
A keepalive reload can land in the very cycle in which the final unit tick would take the count from one to zero. The bench times a second 0xF6 write to the exact expiry edge, measured from the first write. It then requires the pin to stay high and the flag to read zero. It also requires a fresh full period to elapse before the next expiry. Constrained-random runs mix unit, output mode, pulse code and count, and judge each expiry time and pulse width against cycle counts computed from the parameters.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Register indices inside the logical device (decoded by the index/data front end)
    localparam logic [7:0] A_LDEV   = 8'h30;
    localparam logic [7:0] A_OUTCTL = 8'hF0;
    localparam logic [7:0] A_CONF   = 8'hF5;
    localparam logic [7:0] A_COUNT  = 8'hF6;

    // Bit positions inside the configuration register
    localparam int B_EN_STS = 5;
    localparam int B_PULSE  = 4;
    localparam int B_UNIT   = 3;
    localparam int B_GATE   = 7;

    typedef struct packed {
        logic       ldev_en;
        logic       gate;
        logic       wd_en;
        logic       pulse;
        logic       minutes;
        logic [1:0] pw_sel;
    } wd_cfg_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic       sts,
    input  logic [7:0] count,
    output logic [7:0] rdata,
    output wd_cfg_t    cfg,
    output logic       load_cnt,
    output logic       clr_sts
);

    wd_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d    = cfg_q;
        load_cnt = 1'b0;
        clr_sts  = 1'b0;
        if (wr) begin
            case (addr)
                A_LDEV:   cfg_d.ldev_en = wdata[0];
                A_OUTCTL: cfg_d.gate    = wdata[B_GATE];
                A_CONF: begin
                    cfg_d.wd_en   = wdata[B_EN_STS];
                    cfg_d.pulse   = wdata[B_PULSE];
                    cfg_d.minutes = wdata[B_UNIT];
                    cfg_d.pw_sel  = wdata[1:0];
                    clr_sts       = wdata[B_EN_STS];
                end
                A_COUNT:  load_cnt = 1'b1;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            A_LDEV:   rdata = {7'b0, cfg_q.ldev_en};
            A_OUTCTL: rdata = {cfg_q.gate, 7'b0};
            A_CONF:   rdata = {2'b0, sts, cfg_q.pulse, cfg_q.minutes, 1'b0, cfg_q.pw_sel};
            A_COUNT:  rdata = count;
            default:  rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R9: a configuration write without bit 5 leaves the enable cleared or set as written
    p_cfg_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_CONF) |=> (cfg_q.wd_en == $past(wdata[B_EN_STS])));

endmodule

// File: rtl/wdog_tick.sv
module wdog_tick #(
    parameter int CLK_PER_MS  = 33333,
    parameter int MS_PER_SEC  = 1000,
    parameter int SEC_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic minutes,
    output logic ms_tick,
    output logic unit_tick
);

    localparam int MSW = (CLK_PER_MS  > 1) ? $clog2(CLK_PER_MS)  : 1;
    localparam int SW  = (MS_PER_SEC  > 1) ? $clog2(MS_PER_SEC)  : 1;
    localparam int MW  = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;

    typedef struct packed {
        logic [MSW-1:0] ms;
        logic [SW-1:0]  sec;
        logic [MW-1:0]  mn;
    } tick_st_t;

    tick_st_t s_d, s_q;
    logic sec_t, min_t;

    always_comb begin
        s_d     = s_q;
        ms_tick = 1'b0;
        sec_t   = 1'b0;
        min_t   = 1'b0;
        if (!run || restart) begin
            s_d = '0;
        end else begin
            ms_tick = (s_q.ms == MSW'(CLK_PER_MS - 1));
            s_d.ms  = ms_tick ? '0 : s_q.ms + 1'b1;
            if (ms_tick) begin
                sec_t   = (s_q.sec == SW'(MS_PER_SEC - 1));
                s_d.sec = sec_t ? '0 : s_q.sec + 1'b1;
            end
            if (sec_t) begin
                min_t  = (s_q.mn == MW'(SEC_PER_MIN - 1));
                s_d.mn = min_t ? '0 : s_q.mn + 1'b1;
            end
        end
        unit_tick = minutes ? min_t : sec_t;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: no tick of any kind while the timer is stopped
    p_no_tick_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !ms_tick && !unit_tick);

endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
    parameter int PCW  = 13,
    parameter int PW_0 = 1,
    parameter int PW_1 = 25,
    parameter int PW_2 = 125,
    parameter int PW_3 = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       wd_en,
    input  logic       load_cnt,
    input  logic [7:0] load_val,
    input  logic       clr_sts,
    input  logic       pulse_mode,
    input  logic [1:0] pw_sel,
    input  logic       ms_tick,
    input  logic       unit_tick,
    output logic [7:0] count,
    output logic       sts,
    output logic       req
);

    typedef struct packed {
        logic [7:0]     cnt;
        logic           sts;
        logic           req;
        logic [PCW-1:0] pcnt;
    } core_st_t;

    core_st_t s_d, s_q;
    logic     fire;

    function automatic logic [PCW-1:0] pw_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return PCW'(PW_0);
            2'd1:    return PCW'(PW_1);
            2'd2:    return PCW'(PW_2);
            default: return PCW'(PW_3);
        endcase
    endfunction

    always_comb begin
        s_d  = s_q;
        fire = 1'b0;
        if (load_cnt) begin
            // keepalive: reload takes priority over a coincident final decrement
            s_d.cnt  = load_val;
            s_d.req  = 1'b0;
            s_d.pcnt = '0;
        end else if (run && unit_tick && s_q.cnt != 8'd0) begin
            s_d.cnt = s_q.cnt - 8'd1;
            if (s_q.cnt == 8'd1) begin
                fire     = 1'b1;
                s_d.req  = 1'b1;
                s_d.pcnt = pw_of(pw_sel);
            end
        end else if (s_q.req) begin
            if (!wd_en) begin
                s_d.req = 1'b0;
            end else if (pulse_mode && ms_tick) begin
                s_d.pcnt = s_q.pcnt - 1'b1;
                if (s_q.pcnt <= PCW'(1)) s_d.req = 1'b0;
            end
        end
        // expiry flag: set wins over a same-cycle clear
        if (fire)         s_d.sts = 1'b1;
        else if (clr_sts) s_d.sts = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;
    assign sts   = s_q.sts;
    assign req   = s_q.req;

    p_fire_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (s_q.sts && s_q.req && s_q.cnt == 8'd0));

    p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_cnt) |=> $stable(s_q.cnt));

    p_level_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.req && !pulse_mode && wd_en && !load_cnt) |=> s_q.req);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sts && !clr_sts) |=> s_q.sts);

    p_zero_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == 8'd0 && !load_cnt) |=> !$rose(s_q.sts));

    p_reload_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load_cnt |=> (s_q.cnt == $past(load_val) && !s_q.req));

    p_pulse_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.req && pulse_mode) |-> s_q.pcnt != '0);

endmodule

// File: rtl/wdog_ldev.sv
module wdog_ldev
    import wdog_pkg::*;
#(
    parameter int CLK_PER_MS  = 33333,
    parameter int MS_PER_SEC  = 1000,
    parameter int SEC_PER_MIN = 60,
    parameter int PW_0        = 1,
    parameter int PW_1        = 25,
    parameter int PW_2        = 125,
    parameter int PW_3        = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dev_wr,
    input  logic [7:0] dev_addr,
    input  logic [7:0] dev_wdata,
    output logic [7:0] dev_rdata,
    output logic       wdt_rst_n
);

    localparam int PW_A = (PW_0 > PW_1) ? PW_0 : PW_1;
    localparam int PW_B = (PW_2 > PW_3) ? PW_2 : PW_3;
    localparam int PMAX = (PW_A > PW_B) ? PW_A : PW_B;
    localparam int PCW  = $clog2(PMAX + 1);

    wd_cfg_t    cfg;
    logic       load_cnt, clr_sts, run, ms_tick, unit_tick, sts, req;
    logic [7:0] count;

    assign run = cfg.ldev_en & cfg.wd_en;

    wdog_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (dev_wr),
        .addr     (dev_addr),
        .wdata    (dev_wdata),
        .sts      (sts),
        .count    (count),
        .rdata    (dev_rdata),
        .cfg      (cfg),
        .load_cnt (load_cnt),
        .clr_sts  (clr_sts)
    );

    wdog_tick #(
        .CLK_PER_MS  (CLK_PER_MS),
        .MS_PER_SEC  (MS_PER_SEC),
        .SEC_PER_MIN (SEC_PER_MIN)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .restart   (load_cnt),
        .minutes   (cfg.minutes),
        .ms_tick   (ms_tick),
        .unit_tick (unit_tick)
    );

    wdog_core #(
        .PCW  (PCW),
        .PW_0 (PW_0),
        .PW_1 (PW_1),
        .PW_2 (PW_2),
        .PW_3 (PW_3)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .wd_en      (cfg.wd_en),
        .load_cnt   (load_cnt),
        .load_val   (dev_wdata),
        .clr_sts    (clr_sts),
        .pulse_mode (cfg.pulse),
        .pw_sel     (cfg.pw_sel),
        .ms_tick    (ms_tick),
        .unit_tick  (unit_tick),
        .count      (count),
        .sts        (sts),
        .req        (req)
    );

    assign wdt_rst_n = ~(req & cfg.gate);

    // R8: a raised request with the gate closed never reaches the pin
    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !cfg.gate) |-> wdt_rst_n);

endmodule

// File: tb/tb_wdog_ldev.sv
module tb_wdog_ldev;

    localparam int CPM = 2;
    localparam int MPS = 3;
    localparam int SPM = 2;
    localparam int P0 = 1, P1 = 2, P2 = 3, P3 = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dev_wr = 1'b0;
    logic [7:0] dev_addr = 8'h00;
    logic [7:0] dev_wdata = 8'h00;
    logic [7:0] dev_rdata;
    logic       wdt_rst_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    wdog_ldev #(
        .CLK_PER_MS (CPM), .MS_PER_SEC (MPS), .SEC_PER_MIN (SPM),
        .PW_0 (P0), .PW_1 (P1), .PW_2 (P2), .PW_3 (P3)
    ) dut (
        .clk (clk), .rst_n (rst_n), .dev_wr (dev_wr), .dev_addr (dev_addr),
        .dev_wdata (dev_wdata), .dev_rdata (dev_rdata), .wdt_rst_n (wdt_rst_n)
    );

    function automatic int unit_clks(input bit minutes);
        return CPM * MPS * (minutes ? SPM : 1);
    endfunction

    function automatic int pulse_clks(input int sel);
        case (sel)
            0: return P0 * CPM;
            1: return P1 * CPM;
            2: return P2 * CPM;
            default: return P3 * CPM;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        dev_wr = 1'b1; dev_addr = a; dev_wdata = d;
        @(posedge clk);
        @(negedge clk);
        dev_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        dev_addr = a;
        #1;
        v = int'(dev_rdata);
    endtask

    task automatic wait_level(input logic lvl, output int n);
        n = 0;
        while (wdt_rst_n !== lvl && n < 3000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        if (n >= 3000) n = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int v, n;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pin", int'(wdt_rst_n), 1);
        rd(8'h30, v); chk("R1 ldev", v, 0);
        rd(8'hF0, v); chk("R1 gate", v, 0);
        rd(8'hF5, v); chk("R1 conf", v, 0);
        rd(8'hF6, v); chk("R1 count", v, 0);

        // R10 enabled with zero count stays idle
        wr(8'h30, 8'h01); wr(8'hF0, 8'h80); wr(8'hF5, 8'h20);
        repeat (40) @(negedge clk);
        chk("R10 pin", int'(wdt_rst_n), 1);
        rd(8'hF5, v); chk("R10 flag", (v >> 5) & 1, 0);

        // R2/R5 seconds expiry
        wr(8'hF6, 8'd3);
        repeat (7) @(negedge clk);
        rd(8'hF6, v); chk("R2 live count", v, 2);
        wait_level(1'b0, n); chk("R2 expiry time", n + 7, 3 * unit_clks(0));
        rd(8'hF5, v); chk("R5 flag", (v >> 5) & 1, 1);
        rd(8'hF6, v); chk("R5 count zero", v, 0);

        // R6 level hold, release by reload and by disable
        repeat (40) @(negedge clk);
        chk("R6 held", int'(wdt_rst_n), 0);
        wr(8'hF6, 8'd4);
        chk("R6 reload release", int'(wdt_rst_n), 1);
        wait_level(1'b0, n); chk("R6 re-expiry", n, 4 * unit_clks(0));
        wr(8'hF5, 8'h00);
        @(negedge clk);
        chk("R6 disable release", int'(wdt_rst_n), 1);
        rd(8'hF5, v); chk("R9 flag survives disable", (v >> 5) & 1, 1);
        wr(8'hF5, 8'h20);
        rd(8'hF5, v); chk("R9 flag cleared", (v >> 5) & 1, 0);

        // R4 stopped when either enable is off
        wr(8'h30, 8'h00); wr(8'hF6, 8'd2);
        repeat (40) @(negedge clk);
        rd(8'hF6, v); chk("R4 ldev off holds", v, 2);
        wr(8'hF5, 8'h00); wr(8'h30, 8'h01);
        repeat (40) @(negedge clk);
        rd(8'hF6, v); chk("R4 enable off holds", v, 2);
        chk("R4 pin", int'(wdt_rst_n), 1);
        wr(8'hF5, 8'h20);
        wait_level(1'b0, n); chk("R4 runs when both set", n, 2 * unit_clks(0));

        // R3 minutes unit
        wr(8'hF5, 8'h00);
        wr(8'hF5, 8'h28); wr(8'hF6, 8'd2);
        wait_level(1'b0, n); chk("R3 minutes expiry", n, 2 * unit_clks(1));

        // R7 pulse widths
        for (int s = 0; s < 4; s++) begin
            wr(8'hF5, 8'h00);
            wr(8'hF5, 8'(8'h30 | s)); wr(8'hF6, 8'd1);
            wait_level(1'b0, n); chk("R7 pulse expiry", n, unit_clks(0));
            wait_level(1'b1, n); chk("R7 pulse width", n, pulse_clks(s));
            repeat (20) @(negedge clk);
            chk("R7 after pulse", int'(wdt_rst_n), 1);
        end

        // R8 gate closed hides request
        wr(8'hF0, 8'h00); wr(8'hF5, 8'h20); wr(8'hF6, 8'd1);
        repeat (unit_clks(0) + 5) @(negedge clk);
        chk("R8 gated pin", int'(wdt_rst_n), 1);
        rd(8'hF5, v); chk("R8 flag set", (v >> 5) & 1, 1);
        wr(8'hF0, 8'h80);
        chk("R8 gate opened", int'(wdt_rst_n), 0);

        // R11 reload on the expiry edge
        wr(8'hF5, 8'h00); wr(8'hF5, 8'h20); wr(8'hF6, 8'd3);
        repeat (3 * unit_clks(0) - 1) @(posedge clk);
        wr(8'hF6, 8'd3);
        chk("R11 no expiry pin", int'(wdt_rst_n), 1);
        rd(8'hF5, v); chk("R11 no flag", (v >> 5) & 1, 0);
        wait_level(1'b0, n); chk("R11 fresh period", n, 3 * unit_clks(0));

        // constrained random
        for (int i = 0; i < 30; i++) begin
            int cnt, mn, pm, sel;
            cnt = 1 + int'($urandom_range(5));
            mn  = int'($urandom_range(1));
            pm  = int'($urandom_range(1));
            sel = int'($urandom_range(3));
            wr(8'hF5, 8'h00);
            wr(8'hF5, 8'(8'h20 | (pm << 4) | (mn << 3) | sel));
            wr(8'hF6, 8'(cnt));
            wait_level(1'b0, n); chk("R2 R3 random expiry", n, cnt * unit_clks(mn[0]));
            if (pm == 1) begin
                wait_level(1'b1, n); chk("R7 random width", n, pulse_clks(sel));
            end else begin
                repeat (10) @(negedge clk);
                chk("R6 random hold", int'(wdt_rst_n), 0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule